// File: doc/BRIEF.md
# Main Control Decoder for a Nine-Instruction Load/Store Subset

This block is the main control unit of a small single-cycle processor. It is purely combinational. It reads the 6-bit primary opcode and the 6-bit function field of the current instruction word. From these it drives every select and enable the datapath needs for nine instructions: add, sub, ori, lw, sw, beq, lui, j and the empty instruction (nop).

Decoding happens in two steps. The first step turns the opcode, and the function field for register-format words, into a named instruction kind. The states of this block are these kinds: KIND_NONE, KIND_ADD, KIND_SUB, KIND_ORI, KIND_LW, KIND_SW, KIND_BEQ, KIND_LUI and KIND_J. The block has no stored state, so there are no transitions. The kind follows the instruction word within the same cycle. The second step maps each kind to one control word.

Two choices keep the datapath small:
- lui has no shifter. It uses the OR operation with the immediate, and a separate upper-half flag places the result in bits 31:16.
- nop has no entry of its own. An all-zero word is a register-format word with function 000000. That pattern is unrecognised, so every output is low and no state changes.

Top module: `main_ctrl_decoder`

## Requirements
- R1: Opcode 000000 with function 100000 (add) asserts dst_rd_o and reg_we_o and drives alu_op_o = 000. Every other output is 0.
- R2: Opcode 000000 with function 100010 (sub) asserts dst_rd_o and reg_we_o and drives alu_op_o = 001. Every other output is 0.
- R3: Opcode 001101 (ori) asserts alu_imm_o and reg_we_o, drives alu_op_o = 010 and keeps sext_o = 0 (zero extension). Every other output is 0.
- R4: Opcode 100011 (lw) asserts alu_imm_o, mem_to_reg_o, reg_we_o and sext_o and drives alu_op_o = 000. Every other output is 0.
- R5: Opcode 101011 (sw) asserts alu_imm_o, mem_we_o and sext_o and drives alu_op_o = 000. reg_we_o and every other output are 0.
- R6: Opcode 000100 (beq) asserts branch_o and drives alu_op_o = 001. Neither write enable is set, and every other output is 0.
- R7: Opcode 001111 (lui) asserts alu_imm_o, reg_we_o and upper_o and drives alu_op_o = 010, with sext_o = 0. Every other output is 0.
- R8: Opcode 000010 (j) asserts jump_o only. alu_op_o is 000 and every other output is 0.
- R9: Opcode 000000 with any function other than 100000 or 100010 drives all outputs to 0. This includes the all-zero nop word.
- R10: Any opcode outside the set 000000, 001101, 100011, 101011, 000100, 001111 and 000010 drives all outputs to 0.
- R11: For every non-zero opcode the function field has no effect on any output.
- R12: Outputs depend only on the present inputs and settle within the cycle in which the inputs change. There is no register and no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary opcode, instruction bits 31:26 |
| funct_i | input | 6 | Function field, instruction bits 5:0 |
| dst_rd_o | output | 1 | 1: write destination is rd; 0: rt |
| alu_imm_o | output | 1 | 1: ALU operand B is the extended immediate |
| mem_to_reg_o | output | 1 | 1: register write data comes from data memory |
| reg_we_o | output | 1 | Register file write enable, active high |
| mem_we_o | output | 1 | Data memory write enable, active high |
| branch_o | output | 1 | Conditional branch on equality |
| sext_o | output | 1 | 1: sign-extend the immediate; 0: zero-extend |
| alu_op_o | output | 3 | 000 add, 001 subtract, 010 OR |
| upper_o | output | 1 | Place the ALU result in the upper half-word |
| jump_o | output | 1 | Unconditional jump |

## Verification
The only internal state is the decoded instruction kind. A wrong kind shows at the ports in the same evaluation as the input change, as a control word that belongs to another instruction. A misread function field makes an add look like sub or like nothing. A stray kind for an unknown opcode shows up as a write enable that should be low. The bench therefore applies each instruction word and compares the complete 12-bit control word immediately. It covers register-format words with function values near the valid ones, non-zero opcodes carrying arbitrary function bits, and opcodes one bit away from valid ones.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int ALU_W = 3;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OP_W-1:0] OPC_LW    = 6'b100011;
    localparam logic [OP_W-1:0] OPC_SW    = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_LUI   = 6'b001111;
    localparam logic [OP_W-1:0] OPC_J     = 6'b000010;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 3'b000,
        ALU_SUB = 3'b001,
        ALU_OR  = 3'b010
    } alu_op_e;

    typedef enum logic [3:0] {
        KIND_NONE,
        KIND_ADD,
        KIND_SUB,
        KIND_ORI,
        KIND_LW,
        KIND_SW,
        KIND_BEQ,
        KIND_LUI,
        KIND_J
    } instr_kind_e;

    typedef struct packed {
        logic              dst_rd;
        logic              alu_imm;
        logic              mem_to_reg;
        logic              reg_we;
        logic              mem_we;
        logic              branch;
        logic              sext;
        logic [ALU_W-1:0]  alu_op;
        logic              upper;
        logic              jump;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/ctrl_kind_decode.sv
module ctrl_kind_decode
    import ctrl_dec_pkg::*;
(
    input  logic [OP_W-1:0] opcode_i,
    input  logic [FN_W-1:0] funct_i,
    output instr_kind_e     kind_o
);

    instr_kind_e rtype_kind;

    // Function-field sub-decode, only meaningful for register format
    always_comb begin
        unique case (funct_i)
            FN_ADD:  rtype_kind = KIND_ADD;
            FN_SUB:  rtype_kind = KIND_SUB;
            default: rtype_kind = KIND_NONE;
        endcase
    end

    always_comb begin
        unique case (opcode_i)
            OPC_RTYPE: kind_o = rtype_kind;
            OPC_ORI:   kind_o = KIND_ORI;
            OPC_LW:    kind_o = KIND_LW;
            OPC_SW:    kind_o = KIND_SW;
            OPC_BEQ:   kind_o = KIND_BEQ;
            OPC_LUI:   kind_o = KIND_LUI;
            OPC_J:     kind_o = KIND_J;
            default:   kind_o = KIND_NONE;
        endcase
    end

    // R11: non-register formats never take the function-field path
    always_comb begin
        if (opcode_i != OPC_RTYPE) begin
            p_fn_unused_r11: assert (kind_o != KIND_ADD && kind_o != KIND_SUB)
                else $error("function field leaked into non-register decode");
        end
    end

endmodule

// File: rtl/ctrl_table.sv
module ctrl_table
    import ctrl_dec_pkg::*;
(
    input  instr_kind_e kind_i,
    output ctrl_t       ctrl_o
);

    always_comb begin
        ctrl_o = CTRL_IDLE;
        unique case (kind_i)
            KIND_ADD: begin
                ctrl_o.dst_rd = 1'b1;
                ctrl_o.reg_we = 1'b1;
                ctrl_o.alu_op = ALU_ADD;
            end
            KIND_SUB: begin
                ctrl_o.dst_rd = 1'b1;
                ctrl_o.reg_we = 1'b1;
                ctrl_o.alu_op = ALU_SUB;
            end
            KIND_ORI: begin
                ctrl_o.alu_imm = 1'b1;
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.alu_op  = ALU_OR;
            end
            KIND_LW: begin
                ctrl_o.alu_imm    = 1'b1;
                ctrl_o.mem_to_reg = 1'b1;
                ctrl_o.reg_we     = 1'b1;
                ctrl_o.sext       = 1'b1;
                ctrl_o.alu_op     = ALU_ADD;
            end
            KIND_SW: begin
                ctrl_o.alu_imm = 1'b1;
                ctrl_o.mem_we  = 1'b1;
                ctrl_o.sext    = 1'b1;
                ctrl_o.alu_op  = ALU_ADD;
            end
            KIND_BEQ: begin
                ctrl_o.branch = 1'b1;
                ctrl_o.alu_op = ALU_SUB;
            end
            KIND_LUI: begin
                ctrl_o.alu_imm = 1'b1;
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.alu_op  = ALU_OR;
                ctrl_o.upper   = 1'b1;
            end
            KIND_J: begin
                ctrl_o.jump = 1'b1;
            end
            default: ctrl_o = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/main_ctrl_decoder.sv
module main_ctrl_decoder
    import ctrl_dec_pkg::*;
(
    input  logic [OP_W-1:0]  opcode_i,
    input  logic [FN_W-1:0]  funct_i,
    output logic             dst_rd_o,
    output logic             alu_imm_o,
    output logic             mem_to_reg_o,
    output logic             reg_we_o,
    output logic             mem_we_o,
    output logic             branch_o,
    output logic             sext_o,
    output logic [ALU_W-1:0] alu_op_o,
    output logic             upper_o,
    output logic             jump_o
);

    instr_kind_e kind;
    ctrl_t       ctrl;

    ctrl_kind_decode u_kind (
        .opcode_i (opcode_i),
        .funct_i  (funct_i),
        .kind_o   (kind)
    );

    ctrl_table u_table (
        .kind_i (kind),
        .ctrl_o (ctrl)
    );

    always_comb begin
        dst_rd_o     = ctrl.dst_rd;
        alu_imm_o    = ctrl.alu_imm;
        mem_to_reg_o = ctrl.mem_to_reg;
        reg_we_o     = ctrl.reg_we;
        mem_we_o     = ctrl.mem_we;
        branch_o     = ctrl.branch;
        sext_o       = ctrl.sext;
        alu_op_o     = ctrl.alu_op;
        upper_o      = ctrl.upper;
        jump_o       = ctrl.jump;
    end

    // Cross-field consistency of the port-level control word
    always_comb begin
        if (mem_we_o) begin
            p_store_no_regwr_r5: assert (!reg_we_o && sext_o && alu_imm_o)
                else $error("store word also writes register file");
        end
        if (mem_to_reg_o) begin
            p_load_writes_r4: assert (reg_we_o && sext_o && !dst_rd_o)
                else $error("load path without register write");
        end
        if (upper_o) begin
            p_upper_uses_or_r7: assert (alu_op_o == ALU_OR && alu_imm_o && !sext_o)
                else $error("upper placement without OR of immediate");
        end
        if (jump_o) begin
            p_jump_alone_r8: assert (!reg_we_o && !mem_we_o && !branch_o && alu_op_o == ALU_ADD)
                else $error("jump combined with other controls");
        end
        if (branch_o) begin
            p_branch_no_write_r6: assert (!reg_we_o && !mem_we_o && alu_op_o == ALU_SUB)
                else $error("branch writes state");
        end
        if (dst_rd_o) begin
            p_rd_regfmt_r1: assert (opcode_i == OPC_RTYPE && !alu_imm_o && reg_we_o)
                else $error("rd destination outside register format");
        end
    end

endmodule

// File: tb/main_ctrl_decoder_bench.sv
module main_ctrl_decoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode;
    logic [5:0]  funct;
    logic        dst_rd, alu_imm, mem_to_reg, reg_we, mem_we, branch, sext, upper, jump;
    logic [2:0]  alu_op;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    main_ctrl_decoder u_main_ctrl_decoder (
        .opcode_i     (opcode),
        .funct_i      (funct),
        .dst_rd_o     (dst_rd),
        .alu_imm_o    (alu_imm),
        .mem_to_reg_o (mem_to_reg),
        .reg_we_o     (reg_we),
        .mem_we_o     (mem_we),
        .branch_o     (branch),
        .sext_o       (sext),
        .alu_op_o     (alu_op),
        .upper_o      (upper),
        .jump_o       (jump)
    );

    // Packed order: dst_rd alu_imm mem_to_reg reg_we mem_we branch sext alu_op[2:0] upper jump
    function automatic logic [11:0] expect_word(input logic [5:0] op, input logic [5:0] fn);
        case (op)
            6'b000000: begin
                if (fn == 6'b100000)      return 12'b1001_0000_0000; // R1
                else if (fn == 6'b100010) return 12'b1001_0000_0100; // R2
                else                      return 12'b0;              // R9
            end
            6'b001101: return 12'b0101_0000_1000; // R3
            6'b100011: return 12'b0111_0010_0000; // R4
            6'b101011: return 12'b0100_1010_0000; // R5
            6'b000100: return 12'b0000_0100_0100; // R6
            6'b001111: return 12'b0101_0000_1010; // R7
            6'b000010: return 12'b0000_0000_0001; // R8
            default:   return 12'b0;              // R10
        endcase
    endfunction

    function automatic string req_tag(input logic [5:0] op, input logic [5:0] fn);
        case (op)
            6'b000000: return (fn == 6'b100000) ? "R1" : (fn == 6'b100010) ? "R2" : "R9";
            6'b001101: return "R3";
            6'b100011: return "R4";
            6'b101011: return "R5";
            6'b000100: return "R6";
            6'b001111: return "R7";
            6'b000010: return "R8";
            default:   return "R10";
        endcase
    endfunction

    task automatic apply_and_check(input logic [5:0] op, input logic [5:0] fn, input string extra);
        logic [11:0] got;
        logic [11:0] exp;
        @(negedge clk);
        opcode = op;
        funct  = fn;
        #1;
        got = {dst_rd, alu_imm, mem_to_reg, reg_we, mem_we, branch, sext, alu_op, upper, jump};
        exp = expect_word(op, fn);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s%s op=%b fn=%b actual=%b expected=%b",
                     req_tag(op, fn), extra, op, fn, got, exp);
        end
    endtask

    initial begin
        logic [5:0] known_ops [7];
        known_ops = '{6'b000000, 6'b001101, 6'b100011, 6'b101011, 6'b000100, 6'b001111, 6'b000010};
        opcode = '0;
        funct  = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset state: all-zero word is nop, expect idle outputs (R9)
        apply_and_check(6'b000000, 6'b000000, " reset/nop");

        // Directed: each instruction (R1..R8)
        apply_and_check(6'b000000, 6'b100000, " add");
        apply_and_check(6'b000000, 6'b100010, " sub");
        apply_and_check(6'b001101, 6'b000000, " ori");
        apply_and_check(6'b100011, 6'b000000, " lw");
        apply_and_check(6'b101011, 6'b000000, " sw");
        apply_and_check(6'b000100, 6'b000000, " beq");
        apply_and_check(6'b001111, 6'b000000, " lui");
        apply_and_check(6'b000010, 6'b000000, " j");

        // R9: near-miss function values
        apply_and_check(6'b000000, 6'b100001, " addu-like");
        apply_and_check(6'b000000, 6'b100011, " subu-like");
        apply_and_check(6'b000000, 6'b000010, " fn=2");
        apply_and_check(6'b000000, 6'b111111, " fn=all ones");

        // R10: opcodes one bit away from valid ones
        apply_and_check(6'b001100, 6'b100000, " near ori");
        apply_and_check(6'b100001, 6'b000000, " near lw");
        apply_and_check(6'b000011, 6'b000000, " near j");
        apply_and_check(6'b111111, 6'b100010, " all ones");

        // R11: non-zero opcodes carrying add/sub function bits
        apply_and_check(6'b001101, 6'b100000, " R11 ori+addfn");
        apply_and_check(6'b000100, 6'b100010, " R11 beq+subfn");
        apply_and_check(6'b000010, 6'b111111, " R11 j+ones");

        // R12: back-to-back changes settle in the same cycle
        for (int i = 0; i < 7; i++) begin
            apply_and_check(known_ops[i], 6'b100010, " R12 seq");
        end

        // Constrained random mix
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [5:0] op;
            logic [5:0] fn;
            int sel;
            sel = int'($urandom_range(0, 9));
            op  = (sel < 7) ? known_ops[sel] : 6'($urandom);
            sel = int'($urandom_range(0, 3));
            fn  = (sel == 0) ? 6'b100000 : (sel == 1) ? 6'b100010 : 6'($urandom);
            apply_and_check(op, fn, " random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule